// File: doc/BRIEF.md
# Byte-Loaded Double-Buffered DAC Code Register

This block is the write-side logic of a 12-bit converter whose code arrives over an 8-bit bus. A host writes the code in two byte writes. Each byte write is steered into a staging register by one of two active-low byte selects. An active-low load input moves the staged word into the register that drives the converter. The load can happen during a byte write or as a transfer of its own. The bytes can be packed in one of two ways, chosen by a control pin: the top eight code bits come first, or the top four code bits sit in the low nibble of the high byte.

When the mode pin is low, the control pin instead forces the converter code to all-zeros or all-ones. The stored code is not disturbed by this, so releasing the force restores the previous output. All inputs pass through a synchronizer into the system clock domain. A transfer fires once, on the falling edge of the synchronized write strobe.

Top module: `byte_dac_loader`

## Requirements
- R1: A synchronous active-low reset clears the staging register, the DAC register and the select-error flag. After reset, with the mode pin high, `dac_code` reads 0x000.
- R2: A write with only the low-byte select asserted (sel_hi_n=1, sel_lo_n=0) and load_n=1 updates the staging register only. `dac_code` stays unchanged.
- R3: A write with only the high-byte select asserted (sel_hi_n=0, sel_lo_n=1) and load_n=1 updates the staging register only. `dac_code` stays unchanged.
- R4: A byte write with load_n=0 also copies the updated staging word into the DAC register.
- R5: A write with both selects high and load_n=0 copies the staging register into the DAC register, and the bus value is ignored.
- R6: While wr_n stays high, no register changes, whatever the selects, load and bus do.
- R7: When fmt_mode=0, dac_code reads 0x000 if mode_ctrl=0 and 0xFFF if mode_ctrl=1. Writes still act on the registers. When fmt_mode returns to 1, dac_code shows the DAC register again.
- R8: With fmt_mode=1 and mode_ctrl=0 (left-justified), the high byte fills code bits 11..4, and low-byte bits 7..4 fill code bits 3..0.
- R9: With fmt_mode=1 and mode_ctrl=1 (right-justified), high-byte bits 3..0 fill code bits 11..8, and the low byte fills code bits 7..0. While fmt_mode=0, writes use the format last chosen while fmt_mode was high (left-justified after reset).
- R10: Each write assertion causes exactly one transfer, taken on the falling edge of the synchronized wr_n. Bus changes later in the same low pulse are ignored.
- R11: A write with both selects low changes neither register. It sets `sel_err`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_data | input | 8 | Byte data bus |
| wr_n | input | 1 | Write strobe, active low |
| sel_hi_n | input | 1 | High-byte select, active low |
| sel_lo_n | input | 1 | Low-byte select, active low |
| load_n | input | 1 | Load-DAC request, active low |
| fmt_mode | input | 1 | 1: mode_ctrl picks the byte format; 0: mode_ctrl picks the forced code |
| mode_ctrl | input | 1 | Format select or forced-code select |
| dac_code | output | 12 | Code to the converter |
| sel_err | output | 1 | Sticky flag: a write arrived with both selects low |

## Verification
Byte writes are tried in both formats, with and without a concurrent load. Comparing the results shows which code bits each byte lands on, and whether the DAC register follows the staging register or holds its value. Stand-alone transfers with a junk bus value reveal any leak of bus data into the DAC register. Select and load activity with the strobe high reveals any transfer that does not need wr_n. A long write pulse, with the bus changed mid-pulse, tells single-edge capture apart from level capture. Forcing in both polarities, with a write made during the force, shows whether the force is separate from the stored code and whether the remembered format is used.

// File: rtl/byte_dac_pkg.sv
// Shared types for the byte-loaded DAC register block.
// Assumes: one transfer kind per write edge; decode is exclusive.
package byte_dac_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_LO    = 3'd1,
        OP_LO_LD = 3'd2,
        OP_HI    = 3'd3,
        OP_HI_LD = 3'd4,
        OP_XFER  = 3'd5,
        OP_BAD   = 3'd6
    } xfer_op_e;

endpackage

// File: rtl/bdl_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pins.
// Assumes: bits are independent levels; each bit resets to RST_VAL.
module bdl_sync #(
    parameter int           W       = 8,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage: capture the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= RST_VAL;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                // Later stages: shift the previous stage on.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= RST_VAL;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/bdl_wr_decode.sv
// Finds the falling edge of the synchronized write strobe and decodes
// the selects and load into one transfer code for that cycle.
// Also keeps the sticky flag for the illegal both-selects-low write.
// Assumes: inputs are already synchronized to clk.
module bdl_wr_decode
    import byte_dac_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_n_s,
    input  logic     sel_hi_n_s,
    input  logic     sel_lo_n_s,
    input  logic     load_n_s,
    output xfer_op_e op,
    output logic     sel_err
);
    logic wr_n_d;
    logic strobe;
    logic err_q;

    // Delay the synchronized strobe by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_n_d <= 1'b1;
        else        wr_n_d <= wr_n_s;
    end

    assign strobe = wr_n_d & ~wr_n_s;

    // Decode the transfer kind for the single edge cycle.
    always_comb begin
        op = OP_NONE;
        if (strobe) begin
            unique case ({sel_hi_n_s, sel_lo_n_s})
                2'b10:   op = load_n_s ? OP_LO : OP_LO_LD;
                2'b01:   op = load_n_s ? OP_HI : OP_HI_LD;
                2'b11:   op = load_n_s ? OP_NONE : OP_XFER;
                default: op = OP_BAD;
            endcase
        end
    end

    // Set the error flag on an illegal write; only reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)            err_q <= 1'b0;
        else if (op == OP_BAD) err_q <= 1'b1;
    end

    assign sel_err = err_q;

    // R10: one edge produces one transfer cycle only.
    a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    // R11: the flag never drops without reset.
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
endmodule

// File: rtl/bdl_reg_pair.sv
// Staging register and DAC register with byte steering in two formats.
// Assumes: BUS_W < CODE_W <= 2*BUS_W; op is valid for one cycle per edge.
module bdl_reg_pair
    import byte_dac_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int BUS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  xfer_op_e          op,
    input  logic [BUS_W-1:0]  data,
    input  logic              right_fmt,
    output logic [CODE_W-1:0] in_q,
    output logic [CODE_W-1:0] dac_q
);
    localparam int REM_W = CODE_W - BUS_W;

    logic [CODE_W-1:0] in_nx;
    logic [CODE_W-1:0] dac_nx;

    // Steer the byte into its slice of the staging word.
    always_comb begin
        in_nx = in_q;
        unique case (op)
            OP_LO, OP_LO_LD: begin
                if (right_fmt) in_nx[BUS_W-1:0] = data;
                else           in_nx[REM_W-1:0] = data[BUS_W-1 -: REM_W];
            end
            OP_HI, OP_HI_LD: begin
                if (right_fmt) in_nx[CODE_W-1:BUS_W]   = data[REM_W-1:0];
                else           in_nx[CODE_W-1 -: BUS_W] = data;
            end
            default: in_nx = in_q;
        endcase
    end

    // Choose the DAC register update: the new staging word or hold.
    always_comb begin
        dac_nx = dac_q;
        if (op == OP_LO_LD || op == OP_HI_LD || op == OP_XFER) dac_nx = in_nx;
    end

    // Hold both registers, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q  <= '0;
            dac_q <= '0;
        end else begin
            in_q  <= in_nx;
            dac_q <= dac_nx;
        end
    end

    // R6: no transfer, no change.
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NONE) |=> ($stable(in_q) && $stable(dac_q)));

    // R11: the illegal write leaves both registers alone.
    a_r11_bad_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_BAD) |=> ($stable(in_q) && $stable(dac_q)));

    // R2 / R3: a byte write without load keeps the DAC register.
    a_r2_r3_dac_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LO || op == OP_HI) |=> $stable(dac_q));

    // R5: a stand-alone transfer copies the old staging word.
    a_r5_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_XFER) |=> (dac_q == $past(in_q)));

    // R4: a byte write with load leaves both registers equal.
    a_r4_load_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LO_LD || op == OP_HI_LD) |=> (dac_q == in_q));
endmodule

// File: rtl/byte_dac_loader.sv
// Top: write-side logic of a DAC loaded over a byte bus. It synchronizes
// the pins, decodes write edges, keeps the double-buffered code, and
// applies the non-destructive force to all-zeros or all-ones.
// Assumes: all pins are asynchronous levels; reset is synchronous.
module byte_dac_loader
    import byte_dac_pkg::*;
#(
    parameter int CODE_W      = 12,
    parameter int BUS_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  bus_data,
    input  logic              wr_n,
    input  logic              sel_hi_n,
    input  logic              sel_lo_n,
    input  logic              load_n,
    input  logic              fmt_mode,
    input  logic              mode_ctrl,
    output logic [CODE_W-1:0] dac_code,
    output logic              sel_err
);
    localparam int                 PIN_W   = BUS_W + 6;
    localparam logic [PIN_W-1:0]   PIN_RST = {{BUS_W{1'b0}}, 6'b111110};

    logic [PIN_W-1:0]  pins_s;
    logic [BUS_W-1:0]  data_s;
    logic              wr_n_s, sel_hi_n_s, sel_lo_n_s, load_n_s, fmt_s, ctrl_s;
    logic              fmt_q;
    logic              right_fmt;
    xfer_op_e          op;
    logic [CODE_W-1:0] in_q;
    logic [CODE_W-1:0] dac_q;

    bdl_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({bus_data, wr_n, sel_hi_n, sel_lo_n, load_n, fmt_mode, mode_ctrl}),
        .q    (pins_s)
    );

    assign {data_s, wr_n_s, sel_hi_n_s, sel_lo_n_s, load_n_s, fmt_s, ctrl_s} = pins_s;

    // Remember the format chosen while the mode pin is high.
    always_ff @(posedge clk) begin
        if (!rst_n)     fmt_q <= 1'b0;
        else if (fmt_s) fmt_q <= ctrl_s;
    end

    assign right_fmt = fmt_s ? ctrl_s : fmt_q;

    bdl_wr_decode i_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_n_s    (wr_n_s),
        .sel_hi_n_s(sel_hi_n_s),
        .sel_lo_n_s(sel_lo_n_s),
        .load_n_s  (load_n_s),
        .op        (op),
        .sel_err   (sel_err)
    );

    bdl_reg_pair #(.CODE_W(CODE_W), .BUS_W(BUS_W)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .data     (data_s),
        .right_fmt(right_fmt),
        .in_q     (in_q),
        .dac_q    (dac_q)
    );

    // Force the output code without touching the stored word.
    always_comb begin
        if (!fmt_s) dac_code = {CODE_W{ctrl_s}};
        else        dac_code = dac_q;
    end

    // R9: the remembered format only moves while the mode pin is high.
    a_r9_fmt_memory: assert property (@(posedge clk) disable iff (!rst_n)
        !fmt_s |=> $stable(fmt_q));

    // R1 / R8: the staging word only changes on a write edge.
    a_r1_in_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NONE) |=> $stable(in_q));
endmodule

// File: tb/test_byte_dac_loader.sv
`timescale 1ns/1ps
module test_byte_dac_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_data = 8'h00;
    logic        wr_n = 1'b1;
    logic        sel_hi_n = 1'b1;
    logic        sel_lo_n = 1'b1;
    logic        load_n = 1'b1;
    logic        fmt_mode = 1'b1;
    logic        mode_ctrl = 1'b0;
    logic [11:0] dac_code;
    logic        sel_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    byte_dac_loader i_byte_dac_loader (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .wr_n(wr_n),
        .sel_hi_n(sel_hi_n), .sel_lo_n(sel_lo_n), .load_n(load_n),
        .fmt_mode(fmt_mode), .mode_ctrl(mode_ctrl),
        .dac_code(dac_code), .sel_err(sel_err)
    );

    // Row: {req[4], data[8], sel_hi_n, sel_lo_n, load_n, fmt_mode, mode_ctrl, pad[3], expected code[12]}
    localparam logic [31:0] VEC [11] = '{
        {4'd2, 8'hA5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 3'b0, 12'h000}, // R2 low byte, left
        {4'd5, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 3'b0, 12'h00A}, // R5 transfer, bus junk
        {4'd3, 8'h3C, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 3'b0, 12'h00A}, // R3 high byte, left
        {4'd5, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 3'b0, 12'h3CA}, // R5 / R8 transfer
        {4'd4, 8'h81, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'b0, 12'h81A}, // R4 high byte + load
        {4'd8, 8'h5F, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'b0, 12'h815}, // R8 low nibble source
        {4'd9, 8'hE7, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 3'b0, 12'h815}, // R9 high byte, right
        {4'd9, 8'h3B, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'b0, 12'h73B}, // R9 low byte + load
        {4'd9, 8'hFC, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 3'b0, 12'hC3B}, // R9 high nibble only
        {4'd2, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 3'b0, 12'hC3B}, // R2 right, no load
        {4'd5, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 3'b0, 12'hC00}  // R5 transfer
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %03h expected %03h", req, act, exp);
        end
    endtask

    task automatic set_ctl(input logic [7:0] d, input logic sh, input logic sl,
                           input logic ld, input logic fm, input logic ct);
        bus_data = d; sel_hi_n = sh; sel_lo_n = sl; load_n = ld;
        fmt_mode = fm; mode_ctrl = ct;
    endtask

    task automatic pulse(input int low_cycles);
        tick(3);
        wr_n = 1'b0;
        tick(low_cycles);
        wr_n = 1'b1;
        tick(5);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got 0 expected 1 (run completed)");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(2);
        // R1: reset state
        check("R1 code", dac_code, 12'h000);
        check("R1 err", {11'd0, sel_err}, 12'h000);

        foreach (VEC[i]) begin
            logic [31:0] v;
            v = VEC[i];
            set_ctl(v[27:20], v[19], v[18], v[17], v[16], v[15]);
            pulse(4);
            check($sformatf("R%0d row %0d", v[31:28], i), dac_code, v[11:0]);
        end

        // R6: activity with wr_n high does nothing
        set_ctl(8'h77, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        tick(6);
        set_ctl(8'h99, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        tick(6);
        check("R6 dac held", dac_code, 12'hC00);
        set_ctl(8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        pulse(4);
        check("R6 staging held", dac_code, 12'hC00);

        // R10: long pulse, bus changes mid-pulse
        set_ctl(8'h12, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        tick(3);
        wr_n = 1'b0;
        tick(8);
        bus_data = 8'h34;
        tick(8);
        wr_n = 1'b1;
        tick(5);
        check("R10 first value kept", dac_code, 12'hC12);
        set_ctl(8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        pulse(4);
        check("R10 staging single capture", dac_code, 12'hC12);

        // R7: force zeros, force ones, write during force, release
        set_ctl(8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        tick(5);
        check("R7 force zeros", dac_code, 12'h000);
        mode_ctrl = 1'b1;
        tick(5);
        check("R7 force ones", dac_code, 12'hFFF);
        set_ctl(8'h56, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        pulse(4);
        check("R7 forced during write", dac_code, 12'hFFF);
        set_ctl(8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        tick(5);
        check("R7 R9 release shows register", dac_code, 12'hC56);

        // R11: both selects low
        set_ctl(8'h99, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        pulse(4);
        check("R11 flag set", {11'd0, sel_err}, 12'h001);
        check("R11 dac untouched", dac_code, 12'hC56);
        set_ctl(8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        pulse(4);
        check("R11 staging untouched", dac_code, 12'hC56);
        check("R11 flag sticky", {11'd0, sel_err}, 12'h001);

        // R1: reset clears everything again
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        set_ctl(8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        tick(4);
        check("R1 code after reset", dac_code, 12'h000);
        check("R1 flag after reset", {11'd0, sel_err}, 12'h000);
        set_ctl(8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        pulse(4);
        check("R1 staging cleared", dac_code, 12'h000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule